// File: doc/BRIEF.md
# Parity Indicator on a Seven-Segment Digit

This block reads an eight-bit switch word, works out whether it holds an even or an odd number of ones, and shows that answer as a letter on one digit of an eight-digit, common-anode seven-segment display. An even count shows the letter E, and an odd count shows the letter O.

All eight digits share the same segment lines. Both the segment lines and the digit-enable lines are active low. The block enables exactly one digit and keeps the other seven dark. A parameter picks which digit carries the letter.

A second parameter chooses between two output paths. One is purely combinational. The other is registered, with a synchronous active-high reset that blanks the whole display.

Top module: `parity_glyph_display`

## Requirements
- R1: When the input word holds an even number of ones (zero ones and eight ones included), `seg_o` equals 8'b0110_0001, the E glyph. The segment packing is A in bit 7, B in bit 6, C in bit 5, D in bit 4, E in bit 3, F in bit 2, G in bit 1 and the decimal point in bit 0, and a 0 lights a segment.
- R2: When the input word holds an odd number of ones, `seg_o` equals 8'b0000_0011, the O glyph, using the same packing.
- R3: Whenever a letter is shown, `seg_o[0]` (the decimal point) is 1, which keeps the point dark.
- R4: Outside reset, `an_o` equals the bitwise inverse of (1 << DIGIT), so that only the chosen digit is lit. DIGIT defaults to 0, which gives 8'hFE.
- R5: With REGISTERED=1, a change on `sw_i` reaches `seg_o` on the first rising clock edge after the change. Before that edge the previous glyph is still shown.
- R6: With REGISTERED=1, a reset that is high at a rising edge drives `an_o` and `seg_o` to 8'hFF, which blanks every digit.
- R7: The reset is synchronous. Raising `rst_i` between edges leaves both outputs unchanged until the next rising edge.
- R8: With REGISTERED=0, `seg_o` and `an_o` follow `sw_i` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_i | input | 1 | Synchronous reset, active high, which blanks the display |
| sw_i | input | 8 | Switch word, bits 7 down to 0 |
| an_o | output | 8 | Digit enables, active low |
| seg_o | output | 8 | Shared segments {A,B,C,D,E,F,G,DP}, active low |

## Verification
In the registered variant, the glyph and the enables for a word driven at a falling edge are due at the next rising edge. The bench therefore samples one falling edge after it drives a word. It also takes one sample just before that rising edge, which shows the old glyph still held and proves the one-cycle latency. The combinational variant is sampled in the same half-cycle in which its input is driven. A reset raised between edges is sampled both before and after the next rising edge, which separates a synchronous reset from an asynchronous one.

// File: rtl/parity_glyph_pkg.sv
package parity_glyph_pkg;
  localparam int SEG_W = 8;

  // Active-low segment patterns, packed {A,B,C,D,E,F,G,DP}
  localparam logic [SEG_W-1:0] GLYPH_EVEN  = 8'b0110_0001;
  localparam logic [SEG_W-1:0] GLYPH_ODD   = 8'b0000_0011;
  localparam logic [SEG_W-1:0] GLYPH_BLANK = 8'b1111_1111;

  typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} parity_e;

  function automatic logic [SEG_W-1:0] glyph_for(input parity_e p);
    return (p == PAR_ODD) ? GLYPH_ODD : GLYPH_EVEN;
  endfunction

  function automatic logic [7:0] enable_for(input int digit);
    logic [7:0] v;
    v = '1;
    v[digit] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/word_parity.sv
module word_parity #(
  parameter int WORD_W = 8
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              odd_o
);
  logic [WORD_W:0] acc;
  assign acc[0] = 1'b0;
  for (genvar i = 0; i < WORD_W; i++) begin : g_chain
    assign acc[i+1] = acc[i] ^ word_i[i];
  end
  assign odd_o = acc[WORD_W];
endmodule

// File: rtl/glyph_encoder.sv
module glyph_encoder
  import parity_glyph_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter int DIGIT  = 0
) (
  input  logic              odd_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic [DIGITS-1:0] an_o
);
  parity_e par;
  assign par   = parity_e'(odd_i);
  assign seg_o = glyph_for(par);
  for (genvar d = 0; d < DIGITS; d++) begin : g_an
    assign an_o[d] = (d == DIGIT) ? 1'b0 : 1'b1;
  end
endmodule

// File: rtl/display_out_stage.sv
module display_out_stage #(
  parameter int W          = 16,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk_i) begin
      if (rst_i) q_o <= '1;
      else       q_o <= d_i;
    end
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = clk_i ^ rst_i;
    assign q_o = d_i;
  end
endmodule

// File: rtl/parity_glyph_display.sv
module parity_glyph_display
  import parity_glyph_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int DIGITS     = 8,
  parameter int DIGIT      = 0,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [WORD_W-1:0] sw_i,
  output logic [DIGITS-1:0] an_o,
  output logic [SEG_W-1:0]  seg_o
);
  localparam int OUT_W = DIGITS + SEG_W;

  logic              word_odd;
  logic [SEG_W-1:0]  seg_next;
  logic [DIGITS-1:0] an_next;

  word_parity #(.WORD_W(WORD_W)) u_parity (
    .word_i(sw_i),
    .odd_o (word_odd)
  );

  glyph_encoder #(.DIGITS(DIGITS), .DIGIT(DIGIT)) u_enc (
    .odd_i(word_odd),
    .seg_o(seg_next),
    .an_o (an_next)
  );

  display_out_stage #(.W(OUT_W), .REGISTERED(REGISTERED)) u_out (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .d_i  ({an_next, seg_next}),
    .q_o  ({an_o, seg_o})
  );
endmodule

// File: rtl/parity_glyph_checker.sv
module parity_glyph_checker
  import parity_glyph_pkg::*;
#(
  parameter int DIGIT      = 0,
  parameter bit REGISTERED = 1'b1
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic [7:0] an_o,
  input logic [7:0] seg_o,
  input logic       odd_i
);
  AST_DP_DARK: assert property (@(posedge clk_i) disable iff (rst_i)
    (seg_o != GLYPH_BLANK) |-> seg_o[0]); // R3
  AST_ONE_DIGIT: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(~an_o) <= 1); // R4
  AST_GLYPH_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
    (seg_o == GLYPH_EVEN) || (seg_o == GLYPH_ODD) || (seg_o == GLYPH_BLANK)); // R1

  if (REGISTERED) begin : g_reg_chk
    logic rst_seen;
    always_ff @(posedge clk_i) rst_seen <= rst_i;

    AST_GLYPH_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> seg_o == ($past(odd_i) ? GLYPH_ODD : GLYPH_EVEN)); // R5
    AST_ENABLE_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> an_o == ~(8'b1 << DIGIT)); // R4

    always @(negedge clk_i) begin
      if (rst_seen === 1'b1)
        AST_RESET_BLANK: assert (an_o == 8'hFF && seg_o == 8'hFF); // R6
    end
  end else begin : g_comb_chk
    AST_GLYPH_NOW: assert property (@(posedge clk_i) disable iff (rst_i)
      seg_o == (odd_i ? GLYPH_ODD : GLYPH_EVEN)); // R8
  end
endmodule

bind parity_glyph_display parity_glyph_checker #(.DIGIT(DIGIT), .REGISTERED(REGISTERED)) u_chk (
  .clk_i(clk_i),
  .rst_i(rst_i),
  .an_o (an_o),
  .seg_o(seg_o),
  .odd_i(word_odd)
);

// File: tb/parity_glyph_display_bench.sv
module parity_glyph_display_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] sw;
  logic [7:0] an_r, seg_r, an_c, seg_c;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  parity_glyph_display u_parity_glyph_display (
    .clk_i(clk), .rst_i(rst), .sw_i(sw), .an_o(an_r), .seg_o(seg_r)
  );

  parity_glyph_display #(.DIGIT(5), .REGISTERED(1'b0)) u_comb (
    .clk_i(clk), .rst_i(rst), .sw_i(sw), .an_o(an_c), .seg_o(seg_c)
  );

  function automatic logic [7:0] exp_seg(input logic [7:0] w);
    int n = 0;
    for (int i = 0; i < 8; i++) if (w[i]) n++;
    return (n % 2 == 1) ? 8'h03 : 8'h61;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] w);
    @(negedge clk) sw = w;
    #0.1;
    chk("R8 comb seg", seg_c, exp_seg(w));
    chk("R8 comb an", an_c, 8'hDF);
    @(negedge clk);
    chk(exp_seg(w) == 8'h61 ? "R1 even glyph" : "R2 odd glyph", seg_r, exp_seg(w));
    chk("R3 dp dark", {7'b0, seg_r[0]}, 8'h01);
    chk("R4 enable", an_r, 8'hFE);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1D5E);
    rst = 1'b1;
    sw  = 8'h00;
    repeat (3) @(negedge clk);
    chk("R6 reset an", an_r, 8'hFF);
    chk("R6 reset seg", seg_r, 8'hFF);
    rst = 1'b0;
    // directed corners, R1 covers zero and eight ones
    apply(8'h00);
    apply(8'hFF);
    apply(8'h01);
    apply(8'h80);
    apply(8'h7F);
    apply(8'hA5);
    // R5: glyph is held until the next rising edge
    @(negedge clk) sw = 8'h01;
    #1;
    chk("R5 held before edge", seg_r, 8'h61);
    @(negedge clk);
    chk("R5 after edge", seg_r, 8'h03);
    // R7: reset raised between edges takes effect only at an edge
    @(negedge clk) rst = 1'b1;
    #1;
    chk("R7 no async seg", seg_r, 8'h03);
    chk("R7 no async an", an_r, 8'hFE);
    @(negedge clk);
    chk("R6 blank seg", seg_r, 8'hFF);
    chk("R6 blank an", an_r, 8'hFF);
    rst = 1'b0;
    for (int k = 0; k < 300; k++) apply(8'($urandom));
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule